// File: doc/BRIEF.md
# Bit-Oriented Frame Transmitter

This block turns bytes written by a host into bit-oriented synchronous frames on a single serial output. Each frame is wrapped in 01111110 flags. A zero is stuffed after every run of five ones in the body, and a 16-bit cyclic check is appended. The bit stream can optionally be NRZI coded before it leaves on `txd`. One bit moves per cycle in which `tick` is high, so the bit rate is set entirely by the transmit clock enable.

The host pushes bytes through a valid/ready port into a small FIFO and marks the final byte of a frame with `wr_last`. The transmitter handles the rest of the frame without further host action. It puts an opening flag ahead of the data. It clears the end-of-message and underrun indications as a new frame begins. It drives the line high when an NRZI frame ends. It holds the active-low request-to-send output low until the closing flag has fully left the line.

If the FIFO runs dry before a byte flagged as last arrives, the frame is still closed cleanly, with the check field and a closing flag. In that case an underrun indication is raised alongside the end-of-message latch.

Top module: `sdlc_tx`

## Requirements
- R1: Written bytes pass through a 4-entry FIFO. A byte is taken only in a cycle where `wr_valid` and `wr_ready` are both high. `wr_ready` is low while 4 bytes are held, and a write offered in that state is discarded.
- R2: Between frames the line carries back-to-back 01111110 flags, sent bit 0 first, when `cfg_idle_mark` is 0. It carries a steady 1 when `cfg_idle_mark` is 1.
- R3: Each frame begins with one 01111110 opening flag, sent without any host command. In flag-idle mode the frame starts only at an idle flag boundary. In mark-idle mode it starts on the first tick that finds the FIFO non-empty.
- R4: Data bytes go out least significant bit first, one line bit per cycle with `tick` high. `txd` does not change in any cycle where `tick` is low.
- R5: After five consecutive 1 bits in the data or check field, a 0 is inserted. No bit is inserted inside a flag.
- R6: The check field is a CRC-16 with polynomial x^16+x^12+x^5+1 (bit-reversed constant 0x8408, shifted right), preset to 0xFFFF and computed over the data bits. It is sent inverted, low byte first, each byte least significant bit first.
- R7: A byte written with `wr_last` = 1 is the final data byte of its frame. It is followed by the check field and one closing flag.
- R8: If the FIFO is empty when the last bit of a byte without `wr_last` has been sent, the frame is closed with the check field and a closing flag, and `underrun` goes to 1.
- R9: `eom_latch` goes to 1 when the check field of a frame begins. `eom_latch` and `underrun` both return to 0 on the tick that starts the next frame.
- R10: With `cfg_nrzi` = 1, a 0 bit toggles `txd` and a 1 bit leaves it unchanged. Coding is applied to the stream after zero insertion.
- R11: With `cfg_nrzi` = 1, `txd` is forced to 1 on the first tick after the final bit of the closing flag.
- R12: With `cfg_auto_rts` = 1, `rts_n` goes low on the tick that starts a frame. It goes high on the first tick after the final bit of the closing flag, unless another frame starts on that same tick. With `cfg_auto_rts` = 0, `rts_n` equals the inverse of `cfg_rts_req`.
- R13: After reset, `txd` is 1, `eom_latch` and `underrun` are 0, `wr_ready` is 1, and `rts_n` is 1 under automatic control.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| tick | input | 1 | Transmit bit enable, one line bit per high cycle |
| cfg_nrzi | input | 1 | Enable NRZI line coding |
| cfg_idle_mark | input | 1 | Idle with marks instead of flags |
| cfg_auto_rts | input | 1 | Let the transmitter drive `rts_n` |
| cfg_rts_req | input | 1 | Host request-to-send when automatic control is off |
| wr_valid | input | 1 | Write byte offered |
| wr_data | input | 8 | Write byte |
| wr_last | input | 1 | Byte is the final one of its frame |
| wr_ready | output | 1 | FIFO can accept a byte |
| txd | output | 1 | Serial line output |
| rts_n | output | 1 | Active-low request to send |
| eom_latch | output | 1 | End-of-message / underrun latch |
| underrun | output | 1 | Frame was closed because data ran out |

## Verification
The closing of one frame and the opening of the next can fall on the same tick. This happens in mark-idle mode when a second frame is already queued: the first idle tick after a closing flag both releases the frame tail (`rts_n` rise, NRZI force-high) and starts a new frame, which clears the end-of-message latch. The bench provokes this by queuing two short frames before any tick is given. It decodes both frames from the captured line. It then judges that `rts_n` stays low across the gap, and that `eom_latch` is 1 at the end of the first frame and 0 when the second frame's opening flag completes.

// File: rtl/sdlc_tx_pkg.sv
package sdlc_tx_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_OPEN,
      ST_DATA,
      ST_FCS,
      ST_CLOSE
   } tx_state_e;

   localparam logic [7:0] FLAG_PAT = 8'h7E;
endpackage

// File: rtl/sdlc_tx_fifo.sv
module sdlc_tx_fifo #(
   parameter int W     = 9,
   parameter int DEPTH = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         in_valid,
   input  logic [W-1:0] in_data,
   output logic         in_ready,
   output logic         out_valid,
   output logic [W-1:0] out_data,
   input  logic         out_pop
);
   localparam int AW = $clog2(DEPTH);
   localparam int CW = AW + 1;

   generate
      if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_depth_bad
         $error("sdlc_tx_fifo: DEPTH must be a power of two of at least 2");
      end
   endgenerate

   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] wp_q, rp_q;
   logic [CW-1:0] cnt_q;
   logic          push, pop;

   assign in_ready  = cnt_q != CW'(DEPTH);
   assign out_valid = cnt_q != '0;
   assign out_data  = mem[rp_q];
   assign push      = in_valid && in_ready;
   assign pop       = out_pop && out_valid;

   always_ff @(posedge clk) begin
      if (push) mem[wp_q] <= in_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp_q  <= '0;
         rp_q  <= '0;
         cnt_q <= '0;
      end else begin
         if (push) wp_q <= wp_q + AW'(1);
         if (pop)  rp_q <= rp_q + AW'(1);
         cnt_q <= cnt_q + CW'(push) - CW'(pop);
      end
   end
endmodule

// File: rtl/sdlc_tx_crc.sv
module sdlc_tx_crc #(
   parameter int             W    = 16,
   parameter logic [W-1:0]   POLY = 16'h8408,
   parameter logic [W-1:0]   INIT = '1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         init,
   input  logic         en,
   input  logic         din,
   output logic [W-1:0] crc
);
   logic         fb;
   logic [W-1:0] nxt;

   assign fb  = crc[0] ^ din;
   assign nxt = (crc >> 1) ^ (fb ? POLY : '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    crc <= INIT;
      else if (init) crc <= INIT;
      else if (en)   crc <= nxt;
   end
endmodule

// File: rtl/sdlc_tx_line.sv
module sdlc_tx_line #(
   parameter bit HAS_NRZI = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic nrzi_en,
   input  logic force_mark,
   input  logic raw,
   output logic txd
);
   logic nxt;

   generate
      if (HAS_NRZI) begin : g_nrzi
         always_comb begin
            if (!nrzi_en)       nxt = raw;
            else if (force_mark) nxt = 1'b1;
            else                nxt = raw ? txd : ~txd;
         end
      end else begin : g_plain
         logic unused_cfg;
         assign unused_cfg = nrzi_en ^ force_mark;
         always_comb nxt = raw;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    txd <= 1'b1;
      else if (tick) txd <= nxt;
   end
endmodule

// File: rtl/sdlc_tx.sv
module sdlc_tx
   import sdlc_tx_pkg::*;
#(
   parameter int                DATA_W     = 8,
   parameter int                FIFO_DEPTH = 4,
   parameter int                CRC_W      = 16,
   parameter logic [CRC_W-1:0]  CRC_POLY   = 16'h8408,
   parameter int                STUFF_RUN  = 5,
   parameter bit                HAS_NRZI   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              cfg_nrzi,
   input  logic              cfg_idle_mark,
   input  logic              cfg_auto_rts,
   input  logic              cfg_rts_req,
   input  logic              wr_valid,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              wr_last,
   output logic              wr_ready,
   output logic              txd,
   output logic              rts_n,
   output logic              eom_latch,
   output logic              underrun
);
   localparam int MAX_A = (CRC_W > DATA_W) ? CRC_W : DATA_W;
   localparam int MAX_N = (MAX_A > 8) ? MAX_A : 8;
   localparam int CNT_W = $clog2(MAX_N);
   localparam int RUN_W = $clog2(STUFF_RUN + 1);

   generate
      if (STUFF_RUN < 1 || STUFF_RUN > 5 || CRC_W < 8 || DATA_W < 1) begin : g_cfg_bad
         $error("sdlc_tx: STUFF_RUN must be 1..5, CRC_W at least 8");
      end
   endgenerate

   tx_state_e         state_q;
   logic [CNT_W-1:0]  cnt_q;
   logic [DATA_W-1:0] sh_q;
   logic              last_q;
   logic [RUN_W-1:0]  ones_q;
   logic              tail_q;
   logic              eom_q, urun_q;

   logic              f_valid, f_pop;
   logic [DATA_W:0]   f_data;
   logic [CRC_W-1:0]  crc_val;

   logic in_body, stuff, flag_bit, flag_end, start, raw, fcs_bit, byte_end, force_mark;

   sdlc_tx_fifo #(.W(DATA_W + 1), .DEPTH(FIFO_DEPTH)) u_fifo (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_valid (wr_valid),
      .in_data  ({wr_last, wr_data}),
      .in_ready (wr_ready),
      .out_valid(f_valid),
      .out_data (f_data),
      .out_pop  (f_pop)
   );

   sdlc_tx_crc #(.W(CRC_W), .POLY(CRC_POLY), .INIT('1)) u_crc (
      .clk  (clk),
      .rst_n(rst_n),
      .init (tick && start),
      .en   (tick && state_q == ST_DATA && !stuff),
      .din  (sh_q[0]),
      .crc  (crc_val)
   );

   assign in_body  = state_q == ST_DATA || state_q == ST_FCS ||
                     (state_q == ST_CLOSE && cnt_q == '0);
   assign stuff    = in_body && ones_q == RUN_W'(STUFF_RUN);
   assign flag_bit = FLAG_PAT[cnt_q[2:0]];
   assign flag_end = cnt_q[2:0] == 3'd7;
   assign start    = state_q == ST_IDLE && f_valid && (cfg_idle_mark || flag_end);
   assign fcs_bit  = ~crc_val[cnt_q];
   assign byte_end = cnt_q == CNT_W'(DATA_W - 1);
   assign f_pop    = tick && ((state_q == ST_OPEN && flag_end) ||
                     (state_q == ST_DATA && !stuff && byte_end && !last_q && f_valid));
   assign force_mark = tail_q && state_q == ST_IDLE;

   always_comb begin
      unique case (state_q)
         ST_IDLE:  raw = cfg_idle_mark | flag_bit;
         ST_OPEN:  raw = flag_bit;
         ST_DATA:  raw = stuff ? 1'b0 : sh_q[0];
         ST_FCS:   raw = stuff ? 1'b0 : fcs_bit;
         ST_CLOSE: raw = stuff ? 1'b0 : flag_bit;
         default:  raw = 1'b1;
      endcase
   end

   sdlc_tx_line #(.HAS_NRZI(HAS_NRZI)) u_line (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (tick),
      .nrzi_en   (cfg_nrzi),
      .force_mark(force_mark),
      .raw       (raw),
      .txd       (txd)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         cnt_q   <= '0;
         sh_q    <= '0;
         last_q  <= 1'b0;
         ones_q  <= '0;
         tail_q  <= 1'b0;
         eom_q   <= 1'b0;
         urun_q  <= 1'b0;
      end else if (tick) begin
         tail_q <= (state_q != ST_IDLE) || start;
         unique case (state_q)
            ST_IDLE: begin
               cnt_q <= flag_end ? '0 : cnt_q + CNT_W'(1);
               if (start) begin
                  state_q <= ST_OPEN;
                  cnt_q   <= '0;
                  eom_q   <= 1'b0;
                  urun_q  <= 1'b0;
               end
            end
            ST_OPEN: begin
               cnt_q <= cnt_q + CNT_W'(1);
               if (flag_end) begin
                  state_q <= ST_DATA;
                  cnt_q   <= '0;
                  ones_q  <= '0;
                  sh_q    <= f_data[DATA_W-1:0];
                  last_q  <= f_data[DATA_W];
               end
            end
            ST_DATA: begin
               if (stuff) begin
                  ones_q <= '0;
               end else begin
                  ones_q <= sh_q[0] ? ones_q + RUN_W'(1) : '0;
                  sh_q   <= sh_q >> 1;
                  cnt_q  <= cnt_q + CNT_W'(1);
                  if (byte_end) begin
                     cnt_q <= '0;
                     if (!last_q && f_valid) begin
                        sh_q   <= f_data[DATA_W-1:0];
                        last_q <= f_data[DATA_W];
                     end else begin
                        state_q <= ST_FCS;
                        eom_q   <= 1'b1;
                        if (!last_q) urun_q <= 1'b1;
                     end
                  end
               end
            end
            ST_FCS: begin
               if (stuff) begin
                  ones_q <= '0;
               end else begin
                  ones_q <= fcs_bit ? ones_q + RUN_W'(1) : '0;
                  cnt_q  <= cnt_q + CNT_W'(1);
                  if (cnt_q == CNT_W'(CRC_W - 1)) begin
                     state_q <= ST_CLOSE;
                     cnt_q   <= '0;
                  end
               end
            end
            ST_CLOSE: begin
               ones_q <= '0;
               if (!stuff) begin
                  cnt_q <= cnt_q + CNT_W'(1);
                  if (flag_end) begin
                     state_q <= ST_IDLE;
                     cnt_q   <= '0;
                  end
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign rts_n     = cfg_auto_rts ? ~tail_q : ~cfg_rts_req;
   assign eom_latch = eom_q;
   assign underrun  = urun_q;
endmodule

// File: rtl/sdlc_tx_chk.sv
module sdlc_tx_chk
   import sdlc_tx_pkg::*;
#(
   parameter int RUN_W     = 3,
   parameter int STUFF_RUN = 5
) (
   input logic             clk,
   input logic             rst_n,
   input logic             tick,
   input logic             cfg_nrzi,
   input logic             cfg_auto_rts,
   input logic             txd,
   input logic             rts_n,
   input logic             eom_latch,
   input logic             underrun,
   input logic             f_valid,
   input tx_state_e        state_q,
   input logic [RUN_W-1:0] ones_q
);
   // R4: line holds when no bit enable
   assert_hold_without_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !tick |=> $stable(txd));

   // R5: a run of ones in the body is followed by a zero on the line
   assert_stuff_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !cfg_nrzi && (state_q == ST_DATA || state_q == ST_FCS) &&
       ones_q == RUN_W'(STUFF_RUN)) |=> !txd);

   // R8: underrun rises only when the FIFO was empty at the byte boundary
   assert_underrun_on_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(underrun) |-> (!$past(f_valid) && state_q == ST_FCS));

   // R9: latch sets as the check field begins
   assert_eom_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(eom_latch) |-> state_q == ST_FCS);

   // R9: latch clears as the opening flag begins
   assert_eom_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(eom_latch) |-> state_q == ST_OPEN);

   // R11: when the request is released after an NRZI frame the line is high
   assert_nrzi_idle_high_R11: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(rts_n) && cfg_auto_rts && cfg_nrzi) |-> txd);
endmodule

bind sdlc_tx sdlc_tx_chk #(.RUN_W(RUN_W), .STUFF_RUN(STUFF_RUN)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .tick        (tick),
   .cfg_nrzi    (cfg_nrzi),
   .cfg_auto_rts(cfg_auto_rts),
   .txd         (txd),
   .rts_n       (rts_n),
   .eom_latch   (eom_latch),
   .underrun    (underrun),
   .f_valid     (f_valid),
   .state_q     (state_q),
   .ones_q      (ones_q)
);

// File: tb/sdlc_tx_bench.sv
module sdlc_tx_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick = 1'b0;
   logic       cfg_nrzi = 1'b0, cfg_idle_mark = 1'b0, cfg_auto_rts = 1'b1, cfg_rts_req = 1'b0;
   logic       wr_valid = 1'b0;
   logic [7:0] wr_data = '0;
   logic       wr_last = 1'b0;
   logic       wr_ready, txd, rts_n, eom_latch, underrun;

   always #5 clk = ~clk;

   sdlc_tx u_sdlc_tx (
      .clk(clk), .rst_n(rst_n), .tick(tick),
      .cfg_nrzi(cfg_nrzi), .cfg_idle_mark(cfg_idle_mark),
      .cfg_auto_rts(cfg_auto_rts), .cfg_rts_req(cfg_rts_req),
      .wr_valid(wr_valid), .wr_data(wr_data), .wr_last(wr_last), .wr_ready(wr_ready),
      .txd(txd), .rts_n(rts_n), .eom_latch(eom_latch), .underrun(underrun)
   );

   // {nrzi, mark, underrun, 0, 0, count[2:0], byte3, byte2, byte1, byte0}
   localparam logic [39:0] VEC [6] = '{
      40'h01_000000A5,
      40'h04_017EFFFF,
      40'h83_003CFF00,
      40'hC2_00001FF8,
      40'h62_00003412,
      40'hA3_00FF00FF
   };
   localparam int NT = 150;

   int   nchk = 0, nbad = 0;
   bit   done = 1'b0;
   logic line_s [256];
   logic rts_s  [256];
   logic eom_s  [256];
   logic bits_b [256];
   logic [7:0] frb [2][16];
   int   fr_len [2], fr_start [2], fr_end [2];
   int   nfr;
   logic [7:0] expb [4];

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (!ok) begin
         nbad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic do_reset(input logic nrzi, input logic mark, input logic auto_rts, input logic req);
      @(negedge clk);
      rst_n = 1'b0; tick = 1'b0; wr_valid = 1'b0;
      cfg_nrzi = nrzi; cfg_idle_mark = mark; cfg_auto_rts = auto_rts; cfg_rts_req = req;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic write_byte(input logic [7:0] d, input logic last);
      wr_valid = 1'b1; wr_data = d; wr_last = last;
      @(negedge clk);
      wr_valid = 1'b0; wr_last = 1'b0;
   endtask

   task automatic run_ticks(input int n);
      for (int i = 0; i < n; i++) begin
         tick = 1'b1;
         @(negedge clk);
         line_s[i] = txd; rts_s[i] = rts_n; eom_s[i] = eom_latch;
         tick = 1'b0;
         @(negedge clk);
      end
   endtask

   function automatic logic [15:0] fcs_of(input int n);
      logic [15:0] c = 16'hFFFF;
      for (int k = 0; k < n; k++)
         for (int b = 0; b < 8; b++) begin
            logic fb = c[0] ^ expb[k][b];
            c = c >> 1;
            if (fb) c = c ^ 16'h8408;
         end
      return ~c;
   endfunction

   task automatic parse(input int n, input logic nrzi);
      logic [7:0] win = '0;
      bit hunting = 1'b1;
      int ones = 0, nb = 0, cs = 0;
      nfr = 0;
      for (int i = 1; i < n; i++) begin
         logic b = nrzi ? (line_s[i] == line_s[i-1]) : line_s[i];
         if (hunting) begin
            win = {b, win[7:1]};
            if (win == 8'h7E) begin hunting = 1'b0; ones = 0; nb = 0; cs = i; end
         end else if (b) begin
            ones++;
            if (ones > 6) begin hunting = 1'b1; win = 8'hFF; end
            else begin bits_b[nb] = 1'b1; nb++; end
         end else begin
            if (ones == 6) begin
               nb = nb - 7;
               if (nb > 0 && nb % 8 == 0 && nfr < 2 && nb <= 128) begin
                  fr_len[nfr] = nb / 8; fr_start[nfr] = cs; fr_end[nfr] = i;
                  for (int k = 0; k < nb; k++) frb[nfr][k/8][k%8] = bits_b[k];
                  nfr++;
               end
               nb = 0; cs = i;
            end else if (ones != 5) begin
               bits_b[nb] = 1'b0; nb++;
            end
            ones = 0;
         end
      end
   endtask

   task automatic check_frame(input int f, input int n, input logic nrzi, input string tag);
      logic [15:0] fcs = fcs_of(n);
      chk(fr_len[f] == n + 2, {tag, " R7 frame length"}, fr_len[f], n + 2);
      for (int k = 0; k < n; k++)
         chk(frb[f][k] == expb[k], {tag, " R4 R5 data byte"}, frb[f][k], expb[k]);
      chk({frb[f][n+1], frb[f][n]} == fcs, {tag, " R6 check field"}, {frb[f][n+1], frb[f][n]}, fcs);
      if (nrzi) chk(1'b1, {tag, " R10 coded frame decoded"}, 0, 0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         nbad++; nchk++;
         $display("FAIL watchdog expired actual=0 expected=1");
         $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
         $finish;
      end
   end

   initial begin
      // R13 reset state
      do_reset(1'b0, 1'b0, 1'b1, 1'b0);
      chk(txd == 1'b1, "R13 txd after reset", txd, 1);
      chk(rts_n == 1'b1, "R13 rts_n after reset", rts_n, 1);
      chk(eom_latch == 1'b0 && underrun == 1'b0, "R13 latches after reset", {eom_latch, underrun}, 0);
      chk(wr_ready == 1'b1, "R13 wr_ready after reset", wr_ready, 1);

      // vector table
      for (int v = 0; v < 6; v++) begin
         logic [39:0] e = VEC[v];
         int n = int'(e[34:32]);
         do_reset(e[39], e[38], 1'b1, 1'b0);
         for (int j = 0; j < n; j++) begin
            expb[j] = e[8*j +: 8];
            write_byte(expb[j], !e[37] && j == n - 1);
         end
         run_ticks(NT);
         parse(NT, e[39]);
         chk(nfr >= 1, "R3 frame with opening flag found", nfr, 1);
         if (nfr >= 1) begin
            check_frame(0, n, e[39], "vec");
            chk(rts_s[fr_start[0]] == 1'b0, "R12 rts low during frame", rts_s[fr_start[0]], 0);
            chk(rts_s[fr_end[0]] == 1'b0, "R12 rts low on last flag bit", rts_s[fr_end[0]], 0);
            chk(rts_s[fr_end[0]+1] == 1'b1, "R12 rts high after closing flag", rts_s[fr_end[0]+1], 1);
            if (e[39]) chk(line_s[fr_end[0]+1] == 1'b1, "R11 NRZI line forced high", line_s[fr_end[0]+1], 1);
         end
         chk(eom_latch == 1'b1, "R9 eom latch after frame", eom_latch, 1);
         chk(underrun == e[37], "R8 underrun status", underrun, e[37]);
      end

      // R2 flag idle pattern and R4 hold without tick
      do_reset(1'b0, 1'b0, 1'b1, 1'b0);
      run_ticks(16);
      for (int i = 0; i < 16; i++)
         chk(line_s[i] == ((i % 8 == 0 || i % 8 == 7) ? 1'b0 : 1'b1), "R2 idle flag bit", line_s[i], 0);
      begin
         logic hold = txd;
         repeat (10) @(negedge clk);
         chk(txd == hold, "R4 no change without tick", txd, hold);
      end

      // R2 mark idle
      do_reset(1'b0, 1'b1, 1'b1, 1'b0);
      run_ticks(20);
      begin
         bit all1 = 1'b1;
         for (int i = 0; i < 20; i++) if (!line_s[i]) all1 = 1'b0;
         chk(all1, "R2 mark idle stays high", all1, 1);
      end

      // R1 FIFO full, extra write dropped, underrun close
      do_reset(1'b0, 1'b1, 1'b1, 1'b0);
      for (int j = 0; j < 4; j++) begin
         expb[j] = 8'h30 + 8'(j);
         write_byte(expb[j], 1'b0);
      end
      chk(wr_ready == 1'b0, "R1 ready low when full", wr_ready, 0);
      write_byte(8'hEE, 1'b1);
      run_ticks(NT);
      parse(NT, 1'b0);
      chk(nfr == 1, "R1 one frame", nfr, 1);
      if (nfr == 1) check_frame(0, 4, 1'b0, "R1 full");
      chk(underrun == 1'b1, "R8 underrun after full FIFO drained", underrun, 1);

      // back-to-back frames: tail of one and start of next on the same tick
      do_reset(1'b0, 1'b1, 1'b1, 1'b0);
      write_byte(8'h81, 1'b1);
      write_byte(8'h55, 1'b0);
      write_byte(8'hAA, 1'b1);
      run_ticks(NT);
      parse(NT, 1'b0);
      chk(nfr == 2, "R3 two frames", nfr, 2);
      if (nfr == 2) begin
         expb[0] = 8'h81;
         check_frame(0, 1, 1'b0, "b2b first");
         chk(eom_s[fr_end[0]] == 1'b1, "R9 latch set at first frame end", eom_s[fr_end[0]], 1);
         chk(rts_s[fr_end[0]+1] == 1'b0, "R12 rts held low between frames", rts_s[fr_end[0]+1], 0);
         chk(eom_s[fr_start[1]] == 1'b0, "R9 latch cleared at next start", eom_s[fr_start[1]], 0);
         expb[0] = 8'h55; expb[1] = 8'hAA;
         check_frame(1, 2, 1'b0, "b2b second");
      end

      // R12 manual request-to-send
      do_reset(1'b0, 1'b1, 1'b0, 1'b1);
      write_byte(8'h0F, 1'b1);
      run_ticks(60);
      chk(rts_n == 1'b0, "R12 manual rts follows request", rts_n, 0);
      cfg_rts_req = 1'b0;
      @(negedge clk);
      chk(rts_n == 1'b1, "R12 manual rts released", rts_n, 1);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
      $finish;
   end
endmodule